// File: doc/BRIEF.md
# Paged Boot ROM Window for a Z80 Memory Map

This block lets a Z80 see a 16K on-chip boot ROM through a 4K hole at the top of its 64K memory space. The ROM is split into four 4K pages. Exactly one page shows in the F000H–FFFFH window at a time. A memory read in that window drives a ROM address made of the CPU's low twelve address bits and two page bits, and returns the ROM byte with an output enable one clock later.

The two page bits sit in a small register that software loads with an OUT instruction to I/O port 07H. Data bit 0 becomes ROM address bit 12 and data bit 2 becomes ROM address bit 13. The page codes are therefore 00H, 01H, 04H and 05H for pages 0 to 3.

All strobes are sampled on a system clock that runs much faster than the CPU bus. The ROM itself sits outside the block, behind a synchronous read port with one cycle of latency. A page change never disturbs a read that is already in progress. It applies from the next memory read onward.

Top module: `z80_paged_rom_window`

## Requirements
- R1: A synchronous active-low reset clears the page register to page 0 and drops the data output enable. The first window read after reset returns bytes from ROM offset 0000H–0FFFH.
- R2: A memory read (MREQ and RD low) whose address is in F000H–FFFFH drives the ROM address {page, A[11:0]} with the ROM read enable in the same cycle. It raises the data output enable one cycle later, with the ROM byte on the data output.
- R3: A memory read below F000H leaves the ROM read enable and the data output enable low.
- R4: An I/O write (IORQ and WR low) with low address byte 07H loads the page. Data bit 0 drives ROM address bit 12 and data bit 2 drives ROM address bit 13, so 00H, 01H, 04H and 05H select the pages at 0000H, 1000H, 2000H and 3000H.
- R5: Data bits 1 and 3–7 of a page write are ignored. For example, FAH selects page 0 and FFH selects page 3.
- R6: Only the low address byte of an I/O write is decoded, so AB07H loads the page. I/O writes to other low bytes and I/O reads of port 07H leave the page unchanged.
- R7: A memory write in the window never raises the data output enable.
- R8: A page write that lands while a window read is held keeps the old page for the rest of that read. The next read uses the new page.
- R9: A page write strobe held for several cycles loads the page only from the data present in its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the CPU bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Z80 address bus |
| cpu_din | input | 8 | Z80 data bus as driven by the CPU |
| cpu_mreq_n | input | 1 | Memory request strobe, active low |
| cpu_iorq_n | input | 1 | I/O request strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_dout | output | 8 | ROM byte toward the CPU, zero when not enabled |
| cpu_doe | output | 1 | Output enable for cpu_dout |
| rom_addr | output | 14 | Address to the synchronous ROM |
| rom_en | output | 1 | Read enable to the synchronous ROM |
| rom_rdata | input | 8 | ROM read data, valid one cycle after rom_en |

## Verification
A page write and a window read can fall in the same cycle. The collision this block must resolve is a port write that lands while a ROM read is still held. The bench provokes it with a read at F107H, whose low byte also matches the page port. While MREQ and RD stay low, it pulls IORQ and WR low with data 05H. It judges the result by requiring the held read to keep returning page-0 bytes with rom_addr bits 13:12 at zero, and the next separate read at the same address to return the page-3 byte.

// File: rtl/zpw_pkg.sv
// Package: shared widths and page-port constants for the paged ROM window.
// Assumes a 16-bit Z80 address bus and an 8-bit data bus.
package zpw_pkg;
    localparam int ADDR_W      = 16;   // CPU address width
    localparam int DATA_W      = 8;    // CPU data width
    localparam int OFS_W       = 12;   // offset bits inside one page (4K)
    localparam int PAGE_BITS   = 2;    // page select bits (four pages)
    localparam int DBIT_STRIDE = 2;    // page bit g comes from data bit g*stride
    localparam logic [7:0] PAGE_PORT = 8'h07;

    // Data bit that feeds page bit idx.
    function automatic int page_dbit(input int idx);
        return idx * DBIT_STRIDE;
    endfunction
endpackage

// File: rtl/zpw_page_reg.sv
// Page register: captures the page select from an I/O write to the page port.
// Assumes strobes are sampled on clk; a write is taken once, in the first
// cycle its strobe is seen, and the low address byte alone is decoded.
module zpw_page_reg
    import zpw_pkg::*;
#(
    parameter int DATA_W    = zpw_pkg::DATA_W,
    parameter int PAGE_BITS = zpw_pkg::PAGE_BITS,
    parameter logic [7:0] PORT = zpw_pkg::PAGE_PORT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iorq_n,
    input  logic                 wr_n,
    input  logic [7:0]           port_lo,
    input  logic [DATA_W-1:0]    wdata,
    output logic [PAGE_BITS-1:0] page
);
    logic                 strobe;
    logic                 strobe_q;
    logic                 take;
    logic [PAGE_BITS-1:0] sel;
    logic                 unused_wdata;

    // Decode an I/O write aimed at the page port.
    assign strobe = !iorq_n && !wr_n && (port_lo == PORT);
    assign take   = strobe && !strobe_q;
    assign unused_wdata = ^wdata;

    // Pick the data bits that carry the page select.
    for (genvar g = 0; g < PAGE_BITS; g++) begin : g_sel
        assign sel[g] = wdata[page_dbit(g)];
    end

    // Hold the page; load it on the first cycle of a port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            page     <= '0;
        end else begin
            strobe_q <= strobe;
            if (take) begin
                page <= sel;
            end
        end
    end

    // R1: reset leaves page 0 selected.
    assert_reset_page_R1: assert property (@(posedge clk)
        !rst_n |=> (page == '0));

    // R9, R6: the page only moves on the first cycle of a port write.
    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(page));
endmodule

// File: rtl/zpw_window_dec.sv
// Window decoder: flags a memory read that falls inside the top 4K window.
// Assumes the window is the highest page-sized region of the address space.
module zpw_window_dec
#(
    parameter int ADDR_W = zpw_pkg::ADDR_W,
    parameter int OFS_W  = zpw_pkg::OFS_W
) (
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_read,
    output logic [OFS_W-1:0]  offset
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam logic [TAG_W-1:0] WIN_TAG = '1;

    // Match a memory read against the window tag.
    always_comb begin
        win_read = !mreq_n && !rd_n && (addr[ADDR_W-1:OFS_W] == WIN_TAG);
        offset   = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/zpw_read_path.sv
// Read path: forms the ROM address, freezes the page for the length of one
// read, and returns the synchronous ROM byte with an output enable.
// Assumes MREQ rises between successive memory cycles, as on the Z80 bus.
module zpw_read_path
#(
    parameter int DATA_W    = zpw_pkg::DATA_W,
    parameter int OFS_W     = zpw_pkg::OFS_W,
    parameter int PAGE_BITS = zpw_pkg::PAGE_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_read,
    input  logic [OFS_W-1:0]           offset,
    input  logic [PAGE_BITS-1:0]       page,
    output logic [OFS_W+PAGE_BITS-1:0] rom_addr,
    output logic                       rom_en,
    input  logic [DATA_W-1:0]          rom_rdata,
    output logic [DATA_W-1:0]          cpu_dout,
    output logic                       cpu_doe
);
    localparam int ROM_AW = OFS_W + PAGE_BITS;

    logic                 read_q;
    logic                 start;
    logic [PAGE_BITS-1:0] held_page;
    logic [PAGE_BITS-1:0] cur_page;

    // Use the live page at the start of a read and the held one after.
    always_comb begin
        start    = win_read && !read_q;
        cur_page = start ? page : held_page;
        rom_addr = {cur_page, offset};
        rom_en   = win_read;
        cpu_dout = cpu_doe ? rom_rdata : '0;
    end

    // Track read cycles, latch their page, and time the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_q    <= 1'b0;
            held_page <= '0;
            cpu_doe   <= 1'b0;
        end else begin
            read_q  <= win_read;
            cpu_doe <= win_read;
            if (start) begin
                held_page <= page;
            end
        end
    end

    // R8: the page part of the ROM address cannot move inside one read.
    assert_page_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_read && read_q) |-> (rom_addr[ROM_AW-1:OFS_W] == $past(rom_addr[ROM_AW-1:OFS_W])));
endmodule

// File: rtl/z80_paged_rom_window.sv
// Top: maps four 4K pages of an external 16K synchronous ROM into the
// F000H-FFFFH window of a Z80, with the page chosen by an I/O port write.
// Assumes all CPU strobes are synchronous to clk (sampled bus).
module z80_paged_rom_window
#(
    parameter int ADDR_W    = zpw_pkg::ADDR_W,
    parameter int DATA_W    = zpw_pkg::DATA_W,
    parameter int OFS_W     = zpw_pkg::OFS_W,
    parameter int PAGE_BITS = zpw_pkg::PAGE_BITS,
    parameter logic [7:0] PORT = zpw_pkg::PAGE_PORT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_din,
    input  logic                       cpu_mreq_n,
    input  logic                       cpu_iorq_n,
    input  logic                       cpu_rd_n,
    input  logic                       cpu_wr_n,
    output logic [DATA_W-1:0]          cpu_dout,
    output logic                       cpu_doe,
    output logic [OFS_W+PAGE_BITS-1:0] rom_addr,
    output logic                       rom_en,
    input  logic [DATA_W-1:0]          rom_rdata
);
    logic                 win_read;
    logic [OFS_W-1:0]     offset;
    logic [PAGE_BITS-1:0] page;

    zpw_page_reg #(
        .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .PORT(PORT)
    ) i_page_reg (
        .clk(clk), .rst_n(rst_n),
        .iorq_n(cpu_iorq_n), .wr_n(cpu_wr_n),
        .port_lo(cpu_addr[7:0]), .wdata(cpu_din),
        .page(page)
    );

    zpw_window_dec #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W)
    ) i_window_dec (
        .mreq_n(cpu_mreq_n), .rd_n(cpu_rd_n), .addr(cpu_addr),
        .win_read(win_read), .offset(offset)
    );

    zpw_read_path #(
        .DATA_W(DATA_W), .OFS_W(OFS_W), .PAGE_BITS(PAGE_BITS)
    ) i_read_path (
        .clk(clk), .rst_n(rst_n),
        .win_read(win_read), .offset(offset), .page(page),
        .rom_addr(rom_addr), .rom_en(rom_en), .rom_rdata(rom_rdata),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe)
    );

    // R3, R7: any cycle that is not a window read gives no enable next cycle.
    assert_quiet_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mreq_n || cpu_rd_n || (cpu_addr[ADDR_W-1:OFS_W] != '1)) |=> !cpu_doe);

    // R2: a window read at the ports raises the enable one cycle later.
    assert_doe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_mreq_n && !cpu_rd_n && (cpu_addr[ADDR_W-1:OFS_W] == '1)) |=> cpu_doe);
endmodule

// File: tb/test_z80_paged_rom_window.sv
`timescale 1ns/1ps
module test_z80_paged_rom_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic        cpu_mreq_n = 1'b1, cpu_iorq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
    logic [7:0]  cpu_dout;
    logic        cpu_doe;
    logic [13:0] rom_addr;
    logic        rom_en;
    logic [7:0]  rom_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    z80_paged_rom_window i_z80_paged_rom_window (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
        .rom_addr(rom_addr), .rom_en(rom_en), .rom_rdata(rom_rdata)
    );

    // Preloaded ROM image, computed per address so every page differs.
    function automatic logic [7:0] rom_byte(input logic [13:0] a);
        return (a[7:0] ^ {2'b00, a[13:8]}) + {a[13:12], 6'h15};
    endfunction

    // Synchronous ROM model with one cycle of read latency.
    always @(posedge clk) if (rom_en) rom_rdata <= rom_byte(rom_addr);

    // ops: 0 memory read, 1 I/O write, 2 memory write, 3 I/O read
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        exp_doe;
        logic [1:0]  exp_page;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'hF000, 8'h00, 1'b1, 2'd0},  // R2 window bottom
        '{2'd0, 16'hFFFF, 8'h00, 1'b1, 2'd0},  // R2 window top
        '{2'd0, 16'hEFFF, 8'h00, 1'b0, 2'd0},  // R3 just below window
        '{2'd0, 16'h0000, 8'h00, 1'b0, 2'd0},  // R3 bottom of memory
        '{2'd1, 16'h0007, 8'h01, 1'b0, 2'd0},  // R4 code 01H
        '{2'd0, 16'hF123, 8'h00, 1'b1, 2'd1},  // R4 page 1
        '{2'd1, 16'h0007, 8'h04, 1'b0, 2'd0},  // R4 code 04H
        '{2'd0, 16'hF456, 8'h00, 1'b1, 2'd2},  // R4 page 2
        '{2'd1, 16'h0007, 8'h05, 1'b0, 2'd0},  // R4 code 05H
        '{2'd0, 16'hFABC, 8'h00, 1'b1, 2'd3},  // R4 page 3
        '{2'd1, 16'h0007, 8'hFA, 1'b0, 2'd0},  // R5 extra bits ignored
        '{2'd0, 16'hF010, 8'h00, 1'b1, 2'd0},  // R5 -> page 0
        '{2'd1, 16'h0007, 8'hFF, 1'b0, 2'd0},  // R5 all bits set
        '{2'd0, 16'hF010, 8'h00, 1'b1, 2'd3},  // R5 -> page 3
        '{2'd1, 16'h0006, 8'h00, 1'b0, 2'd0},  // R6 other port
        '{2'd0, 16'hF020, 8'h00, 1'b1, 2'd3},  // R6 page unchanged
        '{2'd1, 16'hAB07, 8'h01, 1'b0, 2'd0},  // R6 upper byte ignored
        '{2'd0, 16'hF030, 8'h00, 1'b1, 2'd1},  // R6 -> page 1
        '{2'd3, 16'h0007, 8'h04, 1'b0, 2'd0},  // R6 I/O read ignored
        '{2'd0, 16'hF040, 8'h00, 1'b1, 2'd1},  // R6 page unchanged
        '{2'd2, 16'hF050, 8'h00, 1'b0, 2'd0},  // R7 memory write
        '{2'd0, 16'hF050, 8'h00, 1'b1, 2'd1}   // R7 page unchanged
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_mreq_n = 1'b1; cpu_iorq_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
    endtask

    // Drive one bus cycle of the given kind and sample after one edge.
    task automatic bus_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                          output logic doe, output logic [7:0] dout);
        @(negedge clk);
        cpu_addr = a; cpu_din = d;
        cpu_mreq_n = !(op == 2'd0 || op == 2'd2);
        cpu_iorq_n = !(op == 2'd1 || op == 2'd3);
        cpu_rd_n   = !(op == 2'd0 || op == 2'd3);
        cpu_wr_n   = !(op == 2'd1 || op == 2'd2);
        @(negedge clk);
        doe = cpu_doe; dout = cpu_dout;
        idle();
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [1:0] pg);
        logic doe;
        logic [7:0] dout;
        logic [7:0] exp;
        exp = rom_byte({pg, a[11:0]});
        bus_op(2'd0, a, 8'h00, doe, dout);
        check(doe && dout == exp, req, {7'd0, doe, dout}, {8'h01, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic doe;
        logic [7:0] dout;
        // R1: state while in reset
        repeat (3) @(negedge clk);
        check(cpu_doe == 1'b0, "R1 doe in reset", {15'd0, cpu_doe}, 16'd0);
        rst_n = 1'b1;
        read_chk("R1 page 0 after reset", 16'hF800, 2'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].op, VECS[i].addr, VECS[i].data, doe, dout);
            if (VECS[i].op != 2'd1) begin
                logic [7:0] exp;
                exp = VECS[i].exp_doe ? rom_byte({VECS[i].exp_page, VECS[i].addr[11:0]}) : 8'h00;
                check(doe == VECS[i].exp_doe && dout == exp,
                      $sformatf("vector %0d (R2-R7 table)", i),
                      {7'd0, doe, dout}, {7'd0, VECS[i].exp_doe, exp});
            end
        end

        // R1: reset in mid-run returns to page 0
        bus_op(2'd1, 16'h0007, 8'h05, doe, dout);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_chk("R1 reset mid-run", 16'hF321, 2'd0);

        // R8: page write during a held window read
        @(negedge clk);
        cpu_addr = 16'hF107; cpu_mreq_n = 1'b0; cpu_rd_n = 1'b0;
        @(negedge clk);
        check(cpu_dout == rom_byte({2'd0, 12'h107}), "R8 read before write",
              {8'd0, cpu_dout}, {8'd0, rom_byte({2'd0, 12'h107})});
        cpu_din = 8'h05; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
        @(negedge clk);
        check(rom_addr[13:12] == 2'd0, "R8 rom page held", {14'd0, rom_addr[13:12]}, 16'd0);
        cpu_iorq_n = 1'b1; cpu_wr_n = 1'b1;
        @(negedge clk);
        check(cpu_doe && cpu_dout == rom_byte({2'd0, 12'h107}), "R8 held read keeps old page",
              {7'd0, cpu_doe, cpu_dout}, {8'h01, rom_byte({2'd0, 12'h107})});
        idle();
        @(negedge clk);
        read_chk("R8 next read uses new page", 16'hF107, 2'd3);

        // R9: held write strobe takes the first cycle's data only
        bus_op(2'd1, 16'h0007, 8'h00, doe, dout);
        @(negedge clk);
        cpu_addr = 16'h0007; cpu_din = 8'h01; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
        @(negedge clk);
        cpu_din = 8'h04;
        @(negedge clk);
        idle();
        @(negedge clk);
        read_chk("R9 first data of held write", 16'hF200, 2'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule